// File: doc/BRIEF.md
# Prescaled Timer With Self-Advancing Compare Channels

This block is a periodic-interrupt timer. It holds two counter blocks. Each block pairs a prescale counter with a 32-bit free-running counter. The prescale counter counts up to a programmed limit, returns to zero, and advances the free-running counter by one. A control register starts and stops each block on its own.

Four compare channels watch the free-running counters. A selection register chooses, for each channel, which block that channel follows. When the chosen counter advances onto a channel's compare value, the channel does two things:
- it raises its pending flag;
- it adds its programmed increment to the compare value.

The next match therefore comes one increment later, and software never has to reload the compare value.

Interrupt enables are written through a set register and a clear register, so no read-modify-write is needed. Each channel drives one interrupt line. A line is high while that channel's flag is pending and its enable bit is on. Software reaches everything through a simple word-addressed register bus: a write strobe, and reads that are combinational from the address.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 and every interrupt line is low: run bits, selection, enables, flags, counters, prescale limits, compare values and increments.
- R2: While run bit b of the control register (word address 0) is 0, both counters of block b hold their values.
- R3: While block b runs, its prescale counter (word 9+4b) counts 0,1,…,L, where L is the prescale limit at word 10+4b. On the cycle it equals L it returns to 0, and the free-running counter (word 8+4b) increments. The free-running counter therefore advances once every L+1 cycles.
- R4: When the selected free-running counter steps onto the value in compare register k (word 32+2k), flag k sets on that same clock edge. On that edge the increment at word 33+2k is also added to the compare register.
- R5: Bit k of the selection register (word 1) picks the block that channel k follows: 0 selects block 0 and 1 selects block 1. Steps of the other block never set flag k.
- R6: Writing ones to word 2 sets those enable bits, and writing ones to word 3 clears them. Zero bits leave an enable unchanged. Reading either word returns the four enable bits in bits 3:0.
- R7: The flags read at word 4, bits 3:0. Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. A set flag stays set until it is cleared this way.
- R8: Interrupt line k is high exactly when flag k is pending and enable k is set.
- R9: Free-running counters and compare values wrap modulo 2^32. A counter at 0xFFFFFFFF steps to 0, and that step can match a compare value of 0.
- R10: A bus write to a counter, limit, compare or increment register loads the written value. The write takes precedence over counting or automatic update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 4 | One interrupt line per compare channel |

## Verification
The stimulus table varies three things: the prescale limit, the starting compare value and the increment. It includes a limit of zero, which gives a step every cycle, and an increment of zero. Measuring the cycle count to the first interrupt shows whether the L+1 step period and the match-on-step rule are right. Reading the compare register one cycle before and one cycle on the second match shows that the automatic add happens exactly once per match.

Directed tests cover four further cases:
- a block that is not selected runs past a channel's compare value, while the selected block is stopped, to separate the two routes into a channel;
- a counter wraps past 0xFFFFFFFF onto a compare value of 0;
- zero bits are written to the set, clear and flag registers;
- a counter is loaded while its block is running.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    // word addresses of the shared registers
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'd0;
    localparam logic [ADDR_W-1:0] ADR_SEL   = 6'd1;
    localparam logic [ADDR_W-1:0] ADR_ENSET = 6'd2;
    localparam logic [ADDR_W-1:0] ADR_ENCLR = 6'd3;
    localparam logic [ADDR_W-1:0] ADR_FLAG  = 6'd4;
    localparam int BLK_BASE   = 8;
    localparam int BLK_STRIDE = 4;
    localparam int CMP_BASE   = 32;
    localparam int CMP_STRIDE = 2;

    typedef enum logic [1:0] {
        BF_FRC  = 2'd0,
        BF_PRE  = 2'd1,
        BF_LIM  = 2'd2
    } blk_field_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } bus_wr_t;

    typedef struct packed {
        logic [REG_W-1:0] frc;
        logic [REG_W-1:0] pre;
        logic [REG_W-1:0] lim;
        logic [REG_W-1:0] frc_nxt;
        logic             step;
    } blk_view_t;

    function automatic logic [ADDR_W-1:0] blk_reg(input int b, input blk_field_e f);
        return ADDR_W'(BLK_BASE + BLK_STRIDE * b + int'(f));
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_reg(input int k, input logic is_inc);
        return ADDR_W'(CMP_BASE + CMP_STRIDE * k + int'(is_inc));
    endfunction

    function automatic logic hits(input bus_wr_t w, input logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/pct_prescale_block.sv
module pct_prescale_block
    import pct_pkg::*;
#(
    parameter int BLK_IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  bus_wr_t   wr,
    output blk_view_t view
);

    logic [REG_W-1:0] frc_q, pre_q, lim_q;
    logic ld_frc, ld_pre, ld_lim, at_lim;

    assign ld_frc = hits(wr, blk_reg(BLK_IDX, BF_FRC));
    assign ld_pre = hits(wr, blk_reg(BLK_IDX, BF_PRE));
    assign ld_lim = hits(wr, blk_reg(BLK_IDX, BF_LIM));
    assign at_lim = run && (pre_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            frc_q <= '0;
            pre_q <= '0;
            lim_q <= '0;
        end else begin
            if (ld_lim)
                lim_q <= wr.data;

            if (ld_pre)
                pre_q <= wr.data;
            else if (run)
                pre_q <= at_lim ? '0 : pre_q + 1'b1;

            if (ld_frc)
                frc_q <= wr.data;
            else if (at_lim)
                frc_q <= frc_q + 1'b1;
        end
    end

    always_comb begin
        view.frc     = frc_q;
        view.pre     = pre_q;
        view.lim     = lim_q;
        view.frc_nxt = frc_q + 1'b1;
        view.step    = at_lim && !ld_frc;
    end

endmodule

// File: rtl/pct_compare_chan.sv
module pct_compare_chan
    import pct_pkg::*;
#(
    parameter int CH_IDX  = 0,
    parameter int NUM_BLK = 2,
    parameter int SEL_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_wr_t                   wr,
    input  blk_view_t [NUM_BLK-1:0]   views,
    input  logic      [SEL_W-1:0]     sel,
    output logic      [REG_W-1:0]     cmp,
    output logic      [REG_W-1:0]     inc,
    output logic                      hit
);

    logic ld_cmp, ld_inc;

    assign ld_cmp = hits(wr, cmp_reg(CH_IDX, 1'b0));
    assign ld_inc = hits(wr, cmp_reg(CH_IDX, 1'b1));

    always_comb begin
        hit = 1'b0;
        if (int'(sel) < NUM_BLK)
            hit = views[sel].step && (views[sel].frc_nxt == cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '0;
            inc <= '0;
        end else begin
            if (ld_inc)
                inc <= wr.data;
            if (ld_cmp)
                cmp <= wr.data;
            else if (hit)
                cmp <= cmp + inc;
        end
    end

endmodule

// File: rtl/pct_irq_ctrl.sv
module pct_irq_ctrl
    import pct_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_wr_t            wr,
    input  logic [NUM_CMP-1:0] hit,
    output logic [NUM_CMP-1:0] en,
    output logic [NUM_CMP-1:0] flag,
    output logic [NUM_CMP-1:0] irq
);

    logic [NUM_CMP-1:0] w1c, w1s_en, w1c_en;

    assign w1c    = hits(wr, ADR_FLAG)  ? wr.data[NUM_CMP-1:0] : '0;
    assign w1s_en = hits(wr, ADR_ENSET) ? wr.data[NUM_CMP-1:0] : '0;
    assign w1c_en = hits(wr, ADR_ENCLR) ? wr.data[NUM_CMP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            flag <= '0;
        end else begin
            en   <= (en | w1s_en) & ~w1c_en;
            flag <= (flag & ~w1c) | hit;
        end
    end

    assign irq = flag & en;

endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer
    import pct_pkg::*;
#(
    parameter int NUM_BLK = 2,
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic [NUM_CMP-1:0] irq
);

    localparam int SEL_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int SELV_W  = NUM_CMP * SEL_W;

    bus_wr_t                        wr;
    logic      [NUM_BLK-1:0]        run_q;
    logic      [SELV_W-1:0]         sel_q;
    blk_view_t [NUM_BLK-1:0]        views;
    logic      [NUM_BLK-1:0][REG_W-1:0] frc_all;
    logic      [NUM_CMP-1:0][REG_W-1:0] cmp_all, inc_all;
    logic      [NUM_CMP-1:0]        hit_all, en_q, flag_q;

    assign wr = '{en: bus_wr_en, addr: bus_addr, data: bus_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            sel_q <= '0;
        end else begin
            if (hits(wr, ADR_CTRL))
                run_q <= wr.data[NUM_BLK-1:0];
            if (hits(wr, ADR_SEL))
                sel_q <= wr.data[SELV_W-1:0];
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        pct_prescale_block #(.BLK_IDX(b)) u_blk (
            .clk  (clk),
            .rst  (rst),
            .run  (run_q[b]),
            .wr   (wr),
            .view (views[b])
        );
        assign frc_all[b] = views[b].frc;
    end

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        pct_compare_chan #(
            .CH_IDX  (k),
            .NUM_BLK (NUM_BLK),
            .SEL_W   (SEL_W)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr),
            .views (views),
            .sel   (sel_q[k*SEL_W +: SEL_W]),
            .cmp   (cmp_all[k]),
            .inc   (inc_all[k]),
            .hit   (hit_all[k])
        );
    end

    pct_irq_ctrl #(.NUM_CMP(NUM_CMP)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .hit  (hit_all),
        .en   (en_q),
        .flag (flag_q),
        .irq  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL)
            bus_rdata[NUM_BLK-1:0] = run_q;
        if (bus_addr == ADR_SEL)
            bus_rdata[SELV_W-1:0] = sel_q;
        if (bus_addr == ADR_ENSET || bus_addr == ADR_ENCLR)
            bus_rdata[NUM_CMP-1:0] = en_q;
        if (bus_addr == ADR_FLAG)
            bus_rdata[NUM_CMP-1:0] = flag_q;
        for (int b = 0; b < NUM_BLK; b++) begin
            if (bus_addr == blk_reg(b, BF_FRC)) bus_rdata = views[b].frc;
            if (bus_addr == blk_reg(b, BF_PRE)) bus_rdata = views[b].pre;
            if (bus_addr == blk_reg(b, BF_LIM)) bus_rdata = views[b].lim;
        end
        for (int k = 0; k < NUM_CMP; k++) begin
            if (bus_addr == cmp_reg(k, 1'b0)) bus_rdata = cmp_all[k];
            if (bus_addr == cmp_reg(k, 1'b1)) bus_rdata = inc_all[k];
        end
    end

endmodule

// File: rtl/pct_checker.sv
module pct_checker
    import pct_pkg::*;
#(
    parameter int NUM_BLK = 2,
    parameter int NUM_CMP = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_wr_en,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [REG_W-1:0]               bus_wdata,
    input logic [NUM_CMP-1:0]             irq,
    input logic [NUM_BLK-1:0]             run,
    input logic [NUM_BLK-1:0][REG_W-1:0]  frc_all,
    input logic [NUM_CMP-1:0]             flag,
    input logic [NUM_CMP-1:0]             en
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: state left by reset
    always @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_clear: assert (flag == '0 && en == '0 && irq == '0)
                else $error("R1 state not clear after reset");
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk_chk
        // R2: a stopped block keeps its counter
        a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
            (!run[b] && !(bus_wr_en && bus_addr == blk_reg(b, BF_FRC)))
            |=> $stable(frc_all[b]));
        // R3: the counter moves by at most one per cycle
        a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
            !(bus_wr_en && bus_addr == blk_reg(b, BF_FRC))
            |=> (frc_all[b] == $past(frc_all[b]) ||
                 frc_all[b] == $past(frc_all[b]) + 32'd1));
    end

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_flag_chk
        // R7: a pending flag stays until a one is written to it
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (flag[k] && !(bus_wr_en && bus_addr == ADR_FLAG && bus_wdata[k]))
            |=> flag[k]);
    end

    // R6: set and clear registers
    a_r6_enable_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == ADR_ENSET)
        |=> ((en & $past(bus_wdata[NUM_CMP-1:0])) == $past(bus_wdata[NUM_CMP-1:0])));
    a_r6_enable_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == ADR_ENCLR)
        |=> ((en & $past(bus_wdata[NUM_CMP-1:0])) == '0));

    // R8: no interrupt without an enable
    a_r8_no_irq_unenabled: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> (irq == '0));

endmodule

bind prescaled_cmp_timer pct_checker #(
    .NUM_BLK (NUM_BLK),
    .NUM_CMP (NUM_CMP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (run_q),
    .frc_all   (frc_all),
    .flag      (flag_q),
    .en        (en_q)
);

// File: tb/prescaled_cmp_timer_tb.sv
`timescale 1ns/100ps
module prescaled_cmp_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_cmp_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // word addresses taken from the requirements
    localparam logic [5:0] A_CTRL = 6'd0, A_SEL = 6'd1, A_ENS = 6'd2,
                           A_ENC = 6'd3, A_FLAG = 6'd4;
    localparam logic [5:0] A_FRC0 = 6'd8,  A_PRE0 = 6'd9,  A_LIM0 = 6'd10;
    localparam logic [5:0] A_FRC1 = 6'd12, A_PRE1 = 6'd13, A_LIM1 = 6'd14;
    localparam logic [5:0] A_CMP0 = 6'd32, A_INC0 = 6'd33;
    localparam logic [5:0] A_CMP1 = 6'd34, A_INC1 = 6'd35;

    // stimulus table: prescale limit, first compare value, increment
    localparam int NV = 5;
    localparam logic [31:0] V_LIM [NV] = '{32'd0, 32'd0, 32'd2, 32'd4, 32'd1};
    localparam logic [31:0] V_CMP [NV] = '{32'd1, 32'd3, 32'd2, 32'd1, 32'd5};
    localparam logic [31:0] V_INC [NV] = '{32'd1, 32'd2, 32'd3, 32'd5, 32'd0};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0;
    endtask

    // combinational read, finished before the next falling edge
    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
        rd(A_FRC0, v); check(v == 0, "R1 frc0", v, 0);
        rd(A_CMP0, v); check(v == 0, "R1 cmp0", v, 0);
        rd(A_ENS, v);  check(v == 0, "R1 enables", v, 0);
        rd(A_FLAG, v); check(v == 0, "R1 flags", v, 0);
        check(irq == 0, "R1 irq", 32'(irq), 0);

        // R3 / R4: table of prescale and compare settings
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, 0);
            wr(A_FRC0, 0);
            wr(A_PRE0, 0);
            wr(A_LIM0, V_LIM[i]);
            wr(A_CMP0, V_CMP[i]);
            wr(A_INC0, V_INC[i]);
            wr(A_FLAG, 32'hF);
            wr(A_ENS, 32'h1);
            wr(A_CTRL, 32'h1);
            n = 0;
            while (n < 1000 && !irq[0]) begin
                @(posedge clk);
                #1;
                n++;
            end
            check(n == V_CMP[i] * (V_LIM[i] + 1), "R3 cycles to first match",
                  32'(n), V_CMP[i] * (V_LIM[i] + 1));
            rd(A_CMP0, v);
            check(v == V_CMP[i] + V_INC[i], "R4 compare advanced", v, V_CMP[i] + V_INC[i]);
            if (V_INC[i] != 0) begin
                repeat (V_INC[i] * (V_LIM[i] + 1) - 1) @(posedge clk);
                #1;
                rd(A_CMP0, v);
                check(v == V_CMP[i] + V_INC[i], "R4 no early second add", v,
                      V_CMP[i] + V_INC[i]);
                @(posedge clk);
                #1;
                rd(A_CMP0, v);
                check(v == V_CMP[i] + 2 * V_INC[i], "R4 second match add", v,
                      V_CMP[i] + 2 * V_INC[i]);
            end
        end

        // R10: load while running, write wins over the count
        wr(A_FRC0, 32'h1000);
        rd(A_FRC0, v); check(v == 32'h1000, "R10 load while running", v, 32'h1000);

        // R2: stopped block holds
        wr(A_CTRL, 0);
        rd(A_FRC0, v);
        repeat (10) @(posedge clk);
        #1;
        rd(A_FRC0, v2); check(v2 == v, "R2 frc holds when stopped", v2, v);
        rd(A_PRE0, v);
        repeat (3) @(posedge clk);
        #1;
        rd(A_PRE0, v2); check(v2 == v, "R2 prescale holds when stopped", v2, v);

        // R9: wrap past all ones onto a compare value of zero
        wr(A_FRC0, 32'hFFFF_FFFF);
        wr(A_PRE0, 0);
        wr(A_LIM0, 0);
        wr(A_CMP0, 0);
        wr(A_INC0, 32'hFFFF_FFFF);
        wr(A_FLAG, 32'hF);
        wr(A_CTRL, 32'h1);
        @(posedge clk);
        #1;
        rd(A_FRC0, v);  check(v == 0, "R9 counter wraps", v, 0);
        rd(A_CMP0, v);  check(v == 32'hFFFF_FFFF, "R9 compare add wraps", v, 32'hFFFF_FFFF);
        rd(A_FLAG, v);  check(v[0] == 1'b1, "R9 match on wrap", v, 1);
        wr(A_CTRL, 0);

        // R5: channel 1 follows block 1 only
        wr(A_SEL, 32'h2);
        wr(A_FRC0, 0); wr(A_PRE0, 0);
        wr(A_FRC1, 0); wr(A_PRE1, 0); wr(A_LIM1, 0);
        wr(A_CMP1, 3); wr(A_INC1, 0);
        wr(A_FLAG, 32'hF);
        wr(A_CTRL, 32'h1);
        repeat (10) @(posedge clk);
        #1;
        rd(A_FLAG, v); check(v[1] == 1'b0, "R5 other block ignored", v, 0);
        wr(A_CTRL, 32'h2);
        repeat (2) @(posedge clk);
        #1;
        rd(A_FLAG, v); check(v[1] == 1'b0, "R5 no flag before match", v, 0);
        @(posedge clk);
        #1;
        rd(A_FLAG, v); check(v[1] == 1'b1, "R5 selected block matches", v, 2);
        wr(A_CTRL, 0);

        // R6: set and clear enables
        wr(A_ENC, 32'hF);
        rd(A_ENS, v); check(v == 0, "R6 clear all", v, 0);
        wr(A_ENS, 32'h5);
        rd(A_ENC, v); check(v == 5, "R6 set via set register", v, 5);
        wr(A_ENS, 32'h2);
        rd(A_ENS, v); check(v == 7, "R6 zeros leave bits", v, 7);
        wr(A_ENC, 32'h4);
        rd(A_ENS, v); check(v == 3, "R6 clear one bit", v, 3);

        // R8: line follows flag and enable
        #1;
        check(irq == 4'b0010, "R8 irq with flag and enable", 32'(irq), 2);
        wr(A_ENC, 32'h2);
        check(irq == 4'b0000, "R8 irq off without enable", 32'(irq), 0);

        // R7: write one to clear, zeros ignored
        wr(A_FLAG, 32'h0);
        rd(A_FLAG, v); check(v == 2, "R7 zero write ignored", v, 2);
        wr(A_FLAG, 32'h2);
        rd(A_FLAG, v); check(v == 0, "R7 one clears flag", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule